// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital control half of a multi-channel successive-approximation converter. Software reaches it through four 32-bit registers: conversion result, busy status, control and power-up wait. The analog parts stay outside and are reached through plain digital ports: the channel multiplexer (`ana_chan`), the track/hold strobe (`ana_sample`), the power enable (`ana_pwr`), the trial code for the DAC (`dac_code`) and the comparator answer (`cmp_in`).

Software starts a conversion by turning the power-control bit from 0 to 1 with a legal channel in the same write. The block then waits a programmed number of clocks for the converter to settle. After that it runs one fixed 13-clock frame: one clock of sampling, ten bit trials from the top bit down, and two clocks to latch the result. Clearing the power bit cuts a running conversion short. On completion the result is stored, the busy flag drops and, if enabled, the interrupt line rises. The interrupt stays high until software writes the status register.

Top module: `sar_seq_ctrl`

## Requirements
- R1: Registers are decoded by `bus_addr[3:2]`: 0 result, 1 status, 2 control, 3 wait. Control holds channel in [2:0], power in bit 3 and interrupt enable in bit 5. Wait holds an 8-bit count in [7:0]. All other bits read 0. After reset, result, status and control read 0 and wait reads 2. `bus_rdata` follows `bus_addr` in the same cycle.
- R2: A control write that sets bit 3 while it was 0 and carries channel 0..5 starts a conversion. Status reads 1 from the clock after that write until the conversion ends.
- R3: A rising power write with channel 6 or 7 starts nothing. Status stays 0 and `dac_code` stays 0.
- R4: With wait value D taken at the start write, `ana_sample` is high for exactly one cycle, D cycles after the start edge. D = 0 samples in the very next cycle.
- R5: The frame is 13 clocks: 1 sample, 10 trials, 2 latch. Status still reads 1 D+12 cycles after the start edge and reads 0 one cycle later, with the result already valid.
- R6: During trial n (n = 9 down to 0), `dac_code` equals the bits kept so far OR bit n. Bit n is kept when `cmp_in` is 1 (input at or above the DAC level). Outside trials `dac_code` is 0.
- R7: The result sits in bits [9:0] of the result register, with the upper bits 0. Writes to the result register have no effect.
- R8: A control write with bit 3 clear during a conversion aborts it. Status returns to 0 on the next clock, the old result is kept and no interrupt is raised.
- R9: `irq` is set on the completion edge when bit 5 of control is 1. Any write to the status register clears it, unless a completion sets it on the same edge.
- R10: `ana_chan` takes the channel of the start write and holds it through the conversion. A channel change written during a conversion reaches only the next conversion.
- R11: A control write that keeps bit 3 at 1 does not restart a conversion. Rewriting the wait register during a conversion does not change that conversion's timing.
- R12: `ana_pwr` always equals control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ana_pwr | output | 1 | Converter power enable |
| ana_chan | output | 3 | Channel held for the current conversion |
| ana_sample | output | 1 | Track/hold strobe |
| dac_code | output | 10 | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: 1 when input is at or above DAC level |
| irq | output | 1 | Completion interrupt |

## Verification
Read data is combinational and is due in the same cycle the address is presented. The busy flag, the held channel and the power output are due one clock after the write edge. The sample strobe is due D clocks after the start edge, trial codes in the ten clocks after that, and the result, the falling busy flag and the interrupt exactly D+13 clocks after the start edge. The bench drives inputs 2 ns after a rising edge and compares every output against its reference model at the falling edge. Directed checks count rising edges from the start write so that the last busy cycle and the first idle cycle are each sampled exactly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SAMPLE,
    ST_TRIAL,
    ST_LATCH1,
    ST_LATCH2
  } sar_state_e;

  // register index = bus_addr[3:2]
  localparam logic [1:0] IDX_RESULT = 2'd0;
  localparam logic [1:0] IDX_STATUS = 2'd1;
  localparam logic [1:0] IDX_CTRL   = 2'd2;
  localparam logic [1:0] IDX_WAIT   = 2'd3;

  // control field positions
  localparam int CTRL_PWR_BIT = 3;
  localparam int CTRL_IEN_BIT = 5;

endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CH_W    = 3,
  parameter int NUM_CH  = 6,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [RES_W-1:0]  result,
  output logic              start,
  output logic              abort,
  output logic              pwr,
  output logic              ien,
  output logic [CH_W-1:0]   chan_hold,
  output logic [DLY_W-1:0]  dly,
  output logic [RES_W-1:0]  data_q,
  output logic              irq
);

  logic [CH_W-1:0]  ch_q, ch_d;
  logic             pwr_d, ien_d;
  logic [DLY_W-1:0] dly_d;
  logic [RES_W-1:0] data_d;
  logic [CH_W-1:0]  hold_d;
  logic             irq_d;
  logic             wr_ctrl, wr_wait, wr_stat;
  logic             ch_ok;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_IEN_BIT+1] ^ bus_wdata[4];

  assign wr_ctrl = bus_wr && (bus_addr[3:2] == IDX_CTRL);
  assign wr_wait = bus_wr && (bus_addr[3:2] == IDX_WAIT);
  assign wr_stat = bus_wr && (bus_addr[3:2] == IDX_STATUS);

  assign ch_ok = (int'(bus_wdata[CH_W-1:0]) < NUM_CH);
  assign start = wr_ctrl && bus_wdata[CTRL_PWR_BIT] && !pwr && ch_ok;
  assign abort = wr_ctrl && !bus_wdata[CTRL_PWR_BIT] && busy;

  always_comb begin
    ch_d   = ch_q;
    pwr_d  = pwr;
    ien_d  = ien;
    dly_d  = dly;
    data_d = data_q;
    hold_d = chan_hold;
    irq_d  = irq;
    if (wr_ctrl) begin
      ch_d  = bus_wdata[CH_W-1:0];
      pwr_d = bus_wdata[CTRL_PWR_BIT];
      ien_d = bus_wdata[CTRL_IEN_BIT];
    end
    if (wr_wait) dly_d = bus_wdata[DLY_W-1:0];
    if (start)   hold_d = bus_wdata[CH_W-1:0];
    if (done)    data_d = result;
    if (wr_stat) irq_d = 1'b0;
    if (done && ien) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q      <= '0;
      pwr       <= 1'b0;
      ien       <= 1'b0;
      dly       <= DLY_W'(DLY_RST);
      data_q    <= '0;
      chan_hold <= '0;
      irq       <= 1'b0;
    end else begin
      ch_q      <= ch_d;
      pwr       <= pwr_d;
      ien       <= ien_d;
      dly       <= dly_d;
      data_q    <= data_d;
      chan_hold <= hold_d;
      irq       <= irq_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr[3:2])
      IDX_RESULT: bus_rdata[RES_W-1:0] = data_q;
      IDX_STATUS: bus_rdata[0] = busy;
      IDX_CTRL: begin
        bus_rdata[CH_W-1:0]     = ch_q;
        bus_rdata[CTRL_PWR_BIT] = pwr;
        bus_rdata[CTRL_IEN_BIT] = ien;
      end
      default:    bus_rdata[DLY_W-1:0] = dly;
    endcase
  end

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
  import sar_seq_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DLY_W-1:0] dly,
  input  logic             last_bit,
  output logic             busy,
  output logic             sample,
  output logic             trial,
  output logic             done
);

  sar_state_e       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        cnt_en = 1'b1;
        cnt_d  = dly;
        st_d   = (dly == '0) ? ST_SAMPLE : ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == DLY_W'(1)) st_d = ST_SAMPLE;
        else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - DLY_W'(1);
        end
      end
      ST_SAMPLE: st_d = ST_TRIAL;
      ST_TRIAL:  if (last_bit) st_d = ST_LATCH1;
      ST_LATCH1: st_d = ST_LATCH2;
      ST_LATCH2: st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    if (abort) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign sample = (st_q == ST_SAMPLE);
  assign trial  = (st_q == ST_TRIAL);
  assign done   = (st_q == ST_LATCH2) && !abort;

endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             cmp_in,
  output logic [RES_W-1:0] acc,
  output logic [RES_W-1:0] mask,
  output logic             last_bit,
  output logic [RES_W-1:0] dac_code
);

  logic [RES_W-1:0] acc_d, mask_d;
  logic             en;

  assign en = clear || step;

  always_comb begin
    acc_d  = acc;
    mask_d = mask;
    if (clear) begin
      acc_d  = '0;
      mask_d = {1'b1, {(RES_W-1){1'b0}}};
    end else if (step) begin
      if (cmp_in) acc_d = acc | mask;
      mask_d = mask >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      mask <= '0;
    end else if (en) begin
      acc  <= acc_d;
      mask <= mask_d;
    end
  end

  assign last_bit = mask[0];
  assign dac_code = step ? (acc | mask) : '0;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int CH_W    = 3,
  parameter int NUM_CH  = 6,
  parameter int DLY_W   = 8,
  parameter int DLY_RST = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ana_pwr,
  output logic [CH_W-1:0]   ana_chan,
  output logic              ana_sample,
  output logic [RES_W-1:0]  dac_code,
  input  logic              cmp_in,
  output logic              irq
);

  logic             start, abort, pwr, ien;
  logic             busy, sample, trial, done, last_bit;
  logic [DLY_W-1:0] dly;
  logic [RES_W-1:0] acc, mask, data_q;

  sar_regs #(
    .RES_W(RES_W), .CH_W(CH_W), .NUM_CH(NUM_CH),
    .DLY_W(DLY_W), .DLY_RST(DLY_RST), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .result(acc),
    .start(start), .abort(abort), .pwr(pwr), .ien(ien),
    .chan_hold(ana_chan), .dly(dly), .data_q(data_q), .irq(irq)
  );

  sar_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start(start), .abort(abort), .dly(dly), .last_bit(last_bit),
    .busy(busy), .sample(sample), .trial(trial), .done(done)
  );

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n),
    .clear(sample), .step(trial), .cmp_in(cmp_in),
    .acc(acc), .mask(mask), .last_bit(last_bit), .dac_code(dac_code)
  );

  assign ana_pwr    = pwr;
  assign ana_sample = sample;

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
  parameter int RES_W  = 10,
  parameter int CH_W   = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              start,
  input logic              abort,
  input logic              busy,
  input logic              done,
  input logic              trial,
  input logic              pwr,
  input logic              ien,
  input logic              irq,
  input logic [CH_W-1:0]   ana_chan,
  input logic [RES_W-1:0]  data_q,
  input logic [RES_W-1:0]  mask
);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r3_bad_chan_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd2 && bus_wdata[3] && !pwr && !busy
     && bus_wdata[2:0] >= 3'd6) |=> !busy);

  a_r8_abort_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (!busy && $stable(data_q) && $stable(irq)));

  a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ien) |=> irq);

  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[3:2] == 2'd1 && !(done && ien)) |=> !irq);

  a_r6_one_trial_bit: assert property (@(posedge clk) disable iff (!rst_n)
    trial |-> ($countones(mask) == 1));

  a_r10_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!busy || $stable(ana_chan)));

  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
  .RES_W(RES_W), .CH_W(CH_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .start(start), .abort(abort), .busy(busy), .done(done),
  .trial(trial), .pwr(pwr), .ien(ien), .irq(irq),
  .ana_chan(ana_chan), .data_q(data_q), .mask(mask)
);

// File: tb/sar_seq_ctrl_test.sv
`timescale 1ns/1ps
module sar_seq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ana_pwr, ana_sample, irq, cmp_in;
  logic [2:0]  ana_chan;
  logic [9:0]  dac_code;

  int checks = 0;
  int failures = 0;
  int vin [8] = '{61, 0, 1023, 512, 341, 682, 100, 200};

  always #5 clk = ~clk;

  assign cmp_in = (vin[ana_chan] >= int'(dac_code));

  sar_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_pwr(ana_pwr),
    .ana_chan(ana_chan), .ana_sample(ana_sample), .dac_code(dac_code),
    .cmp_in(cmp_in), .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_data, m_ch, m_dly, m_k, m_D, m_chan, m_acc;
  bit m_pwr, m_ien, m_busy, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_ch = 0; m_dly = 2; m_k = 0; m_D = 0; m_chan = 0;
      m_acc = 0; m_pwr = 0; m_ien = 0; m_busy = 0; m_irq = 0;
    end else begin
      bit fin, wc;
      int f, b;
      fin = 0;
      if (m_busy) begin
        f = m_k - m_D;
        if (f >= 1 && f <= 10) begin
          b = 10 - f;
          if (vin[m_chan] >= (m_acc | (1 << b))) m_acc = m_acc | (1 << b);
        end
        if (m_k == m_D + 12) fin = 1;
        m_k++;
      end
      wc = bus_wr && bus_addr[3:2] == 2'd2;
      if (wc && !bus_wdata[3] && m_busy) begin
        m_busy = 0; fin = 0;
      end
      if (bus_wr && bus_addr[3:2] == 2'd1) m_irq = 0;
      if (fin) begin
        m_data = m_acc; m_busy = 0;
        if (m_ien) m_irq = 1;
      end
      if (wc && bus_wdata[3] && !m_pwr && bus_wdata[2:0] < 6) begin
        m_busy = 1; m_k = 0; m_D = m_dly; m_chan = int'(bus_wdata[2:0]); m_acc = 0;
      end
      if (wc) begin
        m_pwr = bus_wdata[3]; m_ien = bus_wdata[5]; m_ch = int'(bus_wdata[2:0]);
      end
      if (bus_wr && bus_addr[3:2] == 2'd3) m_dly = int'(bus_wdata[7:0]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0: return 32'(m_data);
      2'd1: return 32'(m_busy);
      2'd2: return 32'((int'(m_ien) << 5) | (int'(m_pwr) << 3) | m_ch);
      default: return 32'(m_dly);
    endcase
  endfunction

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      int f;
      logic [9:0] ed;
      f = m_k - m_D;
      ed = (m_busy && f >= 1 && f <= 10) ? 10'(m_acc | (1 << (10 - f))) : 10'd0;
      chk("R1/R2/R7 bus_rdata", bus_rdata, exp_rd(bus_addr));
      chk("R4 ana_sample", 32'(ana_sample), 32'(m_busy && m_k == m_D));
      chk("R6 dac_code", 32'(dac_code), 32'(ed));
      chk("R9 irq", 32'(irq), 32'(m_irq));
      chk("R10 ana_chan", 32'(ana_chan), 32'(m_chan));
      chk("R12 ana_pwr", 32'(ana_pwr), 32'(m_pwr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      bus_addr = 4'(i * 4);
    end
  endtask

  // start on channel ch and check status edge timing for wait value d
  task automatic start_timed(input int ch, input int ien, input int d);
    wr(4'h8, 32'h0);
    wr(4'h8, 32'((ien << 5) | 8 | ch));
    bus_addr = 4'h4;
    @(negedge clk);
    chk("R2 status busy after start", bus_rdata, 32'd1);
    repeat (d + 12) @(posedge clk);
    @(negedge clk);
    chk("R5 status busy in last frame cycle", bus_rdata, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R5 status idle after 13-clock frame", bus_rdata, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(4'h0, 32'd0, "R1 reset result");
    rd(4'h4, 32'd0, "R1 reset status");
    rd(4'h8, 32'd0, "R1 reset control");
    rd(4'hC, 32'd2, "R1 reset wait");

    start_timed(0, 1, 2);
    rd(4'h0, 32'(vin[0]), "R5 result channel 0");
    chk("R9 irq after completion", 32'(irq), 32'd1);
    wr(4'h4, 32'h0);
    chk("R9 irq cleared by status write", 32'(irq), 32'd0);

    wr(4'hC, 32'd0);
    for (int ch = 1; ch < 6; ch++) begin
      start_timed(ch, 0, 0);
      rd(4'h0, 32'(vin[ch]), "R6 result per channel");
    end
    chk("R9 no irq when disabled", 32'(irq), 32'd0);

    wr(4'hC, 32'd5);
    start_timed(3, 0, 5);
    rd(4'h0, 32'(vin[3]), "R4 result with long wait");

    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'(vin[3]), "R7 write to result ignored");

    wr(4'h8, 32'h0);
    wr(4'h8, 32'h2E);
    idle(20);
    rd(4'h4, 32'd0, "R3 channel 6 does not start");
    chk("R3 dac idle", 32'(dac_code), 32'd0);
    wr(4'h8, 32'h0);
    wr(4'h8, 32'h0F);
    idle(20);
    rd(4'h4, 32'd0, "R3 channel 7 does not start");
    rd(4'h0, 32'(vin[3]), "R3 result untouched");

    wr(4'h8, 32'h0);
    wr(4'h8, 32'h2A);
    idle(8);
    wr(4'h8, 32'h20);
    rd(4'h4, 32'd0, "R8 status after abort");
    idle(20);
    rd(4'h0, 32'(vin[3]), "R8 result kept after abort");
    chk("R8 no irq on abort", 32'(irq), 32'd0);

    wr(4'hC, 32'd6);
    wr(4'h8, 32'h0);
    wr(4'h8, 32'h0A);
    wr(4'h8, 32'h0C);
    wr(4'hC, 32'd1);
    idle(20);
    rd(4'h0, 32'(vin[2]), "R10 mid-conversion channel change ignored");
    rd(4'h8, 32'h0C, "R10 control shows new channel");
    chk("R11 no restart while powered", 32'(ana_chan), 32'd2);

    wr(4'hC, 32'd6);
    start_timed(4, 0, 6);
    rd(4'h0, 32'(vin[4]), "R10 next conversion uses new channel");

    wr(4'h8, 32'h0);
    wr(4'h8, 32'h08);
    bus_addr = 4'h4;
    wr(4'hC, 32'd1);
    bus_addr = 4'h4;
    repeat (6 + 9) @(posedge clk);
    @(negedge clk);
    chk("R11 wait rewrite keeps timing", bus_rdata, 32'd1);
    idle(4);
    rd(4'h0, 32'(vin[0]), "R11 result after wait rewrite");

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R5 got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule